// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A producer offers a data word with a valid/ready handshake. The block keeps only the low byte. When it accepts the word, it captures the line-control settings in force in that cycle and shifts out the frame. Each bit is timed by a shared pulse that runs at sixteen times the bit rate.

The frame has four parts, in this order: a low start bit, then five to eight data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Parity can be odd, even, or a fixed 0 or 1. An optional clear-to-send input, passed through a synchroniser, can hold back the start of the next frame. It never interrupts a frame that has already started. A busy flag covers the whole frame.

The block is used between a character source and a pad. The surrounding logic owns the rate pulse, the two enables and the line-control value.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `tx_line` is 1 and `busy` is 0.
- R2: `in_ready` is 1 only when `en_global` and `en_tx` are both 1, no frame is in progress and the clear-to-send condition of R8 holds. A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1.
- R3: An accepted frame starts with a 0 start bit. The data bits follow, least significant first. Their count is `line_ctl[1:0]` + 5, giving codes 0..3 = 5..8 bits. Every bit lasts 16 pulses of `tick16`.
- R4: `line_ctl[2]` = 1 gives two stop bits and 0 gives one. Stop bits are 1 and end the frame.
- R5: When `line_ctl[3]` (parity enable) is 0, no parity bit is sent and `line_ctl[4]` and `line_ctl[5]` have no effect.
- R6: With `line_ctl[3]` = 1 and `line_ctl[5]` = 0, the parity bit follows the last data bit. If `line_ctl[4]` = 0, the count of ones in the data and parity bits together is odd. If `line_ctl[4]` = 1, that count is even.
- R7: With `line_ctl[3]` = 1 and `line_ctl[5]` = 1, the parity bit is constant: 0 when `line_ctl[4]` = 1 and 1 when `line_ctl[4]` = 0.
- R8: With `cts_flow_en` = 1, a frame may start only while the synchronised `cts_in` is 1. The synchroniser is two flops, so a rise of `cts_in` reaches `in_ready` after two clock edges. With `cts_flow_en` = 0, `cts_in` has no effect.
- R9: A frame in progress always completes with the settings captured at acceptance, whatever happens to `cts_in`, the enables or `line_ctl` meanwhile.
- R10: Only `in_data[7:0]` is used. The upper bits of `in_data` have no effect on the line.
- R11: `busy` rises on the edge that accepts a word and falls on the edge that ends the last stop bit. `in_ready` is 0 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| en_global | input | 1 | Block enable |
| en_tx | input | 1 | Transmit enable |
| cts_flow_en | input | 1 | Makes the start of each frame wait for clear-to-send |
| cts_in | input | 1 | Asynchronous clear-to-send, active high |
| line_ctl | input | 6 | [1:0] word length minus 5, [2] two stop bits, [3] parity enable, [4] even select, [5] stick select |
| in_data | input | IN_DATA_W (16) | Character to send; only bits 7:0 are used |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Block accepts a word on this edge if `in_valid` is 1 |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
The bench builds the block with its default parameters: 16 pulses per bit, a two-stage synchroniser and a 16-bit data port. The frame is at most twelve bits long, so a sweep is cheap. The bench sweeps every word-length code, both stop settings and all five parity modes against several data bytes, with a pulse on every cycle. This covers every frame shape the control word can produce. One frame is also sent with a pulse on every third cycle, which checks that bit timing follows the pulses and not the clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int UTX_BYTE_W    = 8;
  localparam int UTX_FRAME_MAX = 1 + UTX_BYTE_W + 1 + 2;
  localparam int UTX_LEN_W     = $clog2(UTX_FRAME_MAX + 1);

  // Bit 5 down to bit 0 of the line-control word.
  typedef struct packed {
    logic       par_stick;
    logic       par_even;
    logic       par_en;
    logic       stop2;
    logic [1:0] wlen_code;
  } line_ctl_t;

  function automatic logic [3:0] data_bits(line_ctl_t c);
    return 4'd5 + {2'b00, c.wlen_code};
  endfunction

  function automatic logic [UTX_BYTE_W-1:0] mask_data(logic [UTX_BYTE_W-1:0] d,
                                                      line_ctl_t c);
    logic [UTX_BYTE_W-1:0] m;
    m = '0;
    for (int i = 0; i < UTX_BYTE_W; i++)
      if (i < int'(data_bits(c))) m[i] = d[i];
    return m;
  endfunction

  function automatic logic parity_value(logic [UTX_BYTE_W-1:0] d, line_ctl_t c);
    logic x;
    x = ^mask_data(d, c);
    if (c.par_stick) return ~c.par_even;
    if (c.par_even)  return x;
    return ~x;
  endfunction

  function automatic logic [UTX_LEN_W-1:0] frame_len(line_ctl_t c);
    logic [UTX_LEN_W-1:0] n;
    n = UTX_LEN_W'(1) + UTX_LEN_W'(data_bits(c));
    if (c.par_en) n = n + UTX_LEN_W'(1);
    n = n + (c.stop2 ? UTX_LEN_W'(2) : UTX_LEN_W'(1));
    return n;
  endfunction

  // Bit 0 leaves first; unused upper positions stay 1 (stop level).
  function automatic logic [UTX_FRAME_MAX-1:0] build_frame(logic [UTX_BYTE_W-1:0] d,
                                                          line_ctl_t c);
    logic [UTX_FRAME_MAX-1:0] f;
    int n;
    n = int'(data_bits(c));
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < UTX_BYTE_W; i++)
      if (i < n) f[1 + i] = d[i];
    if (c.par_en) f[1 + n] = parity_value(d, c);
    return f;
  endfunction

endpackage

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic bit_end
);
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt;

  assign bit_end = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart)         cnt <= '0;
    else if (run && tick)     cnt <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/uart_frame_shift.sv
module uart_frame_shift #(
  parameter int FRAME_W = 12,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   len_in,
  input  logic               advance,
  output logic               line,
  output logic               busy,
  output logic [LEN_W-1:0]   bits_left
);
  logic [FRAME_W-1:0] sr;

  assign line = sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '1;
      busy      <= 1'b0;
      bits_left <= '0;
    end else if (load) begin
      sr        <= frame_in;
      busy      <= 1'b1;
      bits_left <= len_in;
    end else if (advance) begin
      if (bits_left == LEN_W'(1)) begin
        sr        <= '1;
        busy      <= 1'b0;
        bits_left <= '0;
      end else begin
        sr        <= {1'b1, sr[FRAME_W-1:1]};
        bits_left <= bits_left - LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int IN_DATA_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick16,
  input  logic                 en_global,
  input  logic                 en_tx,
  input  logic                 cts_flow_en,
  input  logic                 cts_in,
  input  logic [5:0]           line_ctl,
  input  logic [IN_DATA_W-1:0] in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 tx_line,
  output logic                 busy
);
  logic                     cts_synced;
  logic                     clear_to_send;
  logic                     tx_enabled;
  logic                     accept;
  logic                     bit_end;
  logic [UTX_LEN_W-1:0]     bits_left;
  logic [UTX_BYTE_W-1:0]    byte_in;
  line_ctl_t                ctl;
  logic [UTX_FRAME_MAX-1:0] frame_word;
  logic [UTX_LEN_W-1:0]     frame_bits;

  uart_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cts_in), .sync_out(cts_synced)
  );

  assign clear_to_send = !cts_flow_en || cts_synced;
  assign tx_enabled    = en_global && en_tx;
  assign in_ready      = tx_enabled && clear_to_send && !busy;
  assign accept        = in_valid && in_ready;

  assign byte_in    = in_data[UTX_BYTE_W-1:0];
  assign ctl        = line_ctl_t'(line_ctl);
  assign frame_word = build_frame(byte_in, ctl);
  assign frame_bits = frame_len(ctl);

  uart_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(accept),
    .tick(tick16), .bit_end(bit_end)
  );

  uart_frame_shift #(.FRAME_W(UTX_FRAME_MAX), .LEN_W(UTX_LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .frame_in(frame_word),
    .len_in(frame_bits), .advance(bit_end), .line(tx_line),
    .busy(busy), .bits_left(bits_left)
  );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       busy,
  input logic       tx_line,
  input logic       en_global,
  input logic       en_tx,
  input logic       cts_flow_en,
  input logic       cts_synced,
  input logic       bit_end,
  input logic [3:0] bits_left
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  a_r2_ready_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (en_global && en_tx));

  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !tx_line));

  a_r4_final_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bits_left == 4'd1) |-> tx_line);

  a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && cts_flow_en) |-> cts_synced);

  a_r9_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> $stable(tx_line));

  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> busy);

  a_r11_no_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .busy(busy), .tx_line(tx_line), .en_global(en_global), .en_tx(en_tx),
  .cts_flow_en(cts_flow_en), .cts_synced(cts_synced), .bit_end(bit_end),
  .bits_left(bits_left)
);

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/1ps
module tb_uart_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick16 = 1'b1;
  logic        en_global = 1'b0, en_tx = 1'b0;
  logic        cts_flow_en = 1'b0, cts_in = 1'b0;
  logic [5:0]  line_ctl = 6'd3;
  logic [15:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, tx_line, busy;

  int errors = 0, checks = 0, cyc = 0, tick_p = 1, tdiv = 0;
  bit finished = 0;

  uart_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .en_global(en_global),
    .en_tx(en_tx), .cts_flow_en(cts_flow_en), .cts_in(cts_in),
    .line_ctl(line_ctl), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tx_line(tx_line), .busy(busy)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    tdiv = (tdiv >= tick_p - 1) ? 0 : tdiv + 1;
    tick16 = (tdiv == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  // Offer a word, return the cycle count of the accepting edge.
  task automatic offer(input logic [15:0] d, output int e);
    @(negedge clk);
    in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    e = cyc;
  endtask

  task automatic check_frame(input int e, input logic [7:0] d, input logic [5:0] c);
    int n, nb, ones, p, bitlen;
    int exp_b[12];
    string tg[12];
    n = 5 + int'(c[1:0]);
    nb = 0;
    exp_b[nb] = 0; tg[nb] = "R3 start"; nb++;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      exp_b[nb] = int'(d[i]); tg[nb] = "R3 data"; nb++;
      ones += int'(d[i]);
    end
    if (c[3]) begin
      if (c[5]) begin p = c[4] ? 0 : 1; tg[nb] = "R7 stick parity"; end
      else begin
        p = c[4] ? (ones % 2) : 1 - (ones % 2);
        tg[nb] = "R6 parity";
      end
      exp_b[nb] = p; nb++;
    end
    for (int s = 0; s < (c[2] ? 2 : 1); s++) begin
      exp_b[nb] = 1; tg[nb] = c[3] ? "R4 stop" : "R5 stop after data"; nb++;
    end
    bitlen = 16 * tick_p;
    for (int k = 0; k < nb; k++) begin
      wait_to(e + k * bitlen + bitlen / 2);
      chk(tx_line == exp_b[k], tg[k], int'(tx_line), exp_b[k]);
      if (k == nb - 1) begin
        chk(busy == 1'b1, "R11 busy during last bit", int'(busy), 1);
        chk(in_ready == 1'b0, "R11 not ready while busy", int'(in_ready), 0);
      end
    end
    wait_to(e + nb * bitlen + tick_p);
    chk(busy == 1'b0, "R11 busy ends with frame", int'(busy), 0);
    chk(tx_line == 1'b1, "R1 line idles high", int'(tx_line), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    int e;
    logic [7:0] pats[3];
    logic [5:0] c;
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hF1;

    repeat (3) @(negedge clk);
    chk(tx_line == 1'b1, "R1 reset line", int'(tx_line), 1);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 ready off when disabled", int'(in_ready), 0);

    // R2: each enable alone is not enough
    in_valid = 1'b1; en_global = 1'b1; en_tx = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R2 global only", int'(in_ready), 0);
    chk(busy == 1'b0 && tx_line == 1'b1, "R2 no start when tx disabled", int'(busy), 0);
    en_global = 1'b0; en_tx = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R2 tx only", int'(in_ready), 0);
    in_valid = 1'b0; en_global = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 both enables", int'(in_ready), 1);

    // R3 R4 R5 R6 R7: sweep of all frame shapes
    for (int wl = 0; wl < 4; wl++)
      for (int st = 0; st < 2; st++)
        for (int pm = 0; pm < 5; pm++)
          for (int di = 0; di < 3; di++) begin
            case (pm)
              0: c = {2'b11, 1'b0, 1'b0, 2'b00}; // parity off, selects set (R5)
              1: c = {2'b00, 1'b1, 1'b0, 2'b00}; // odd
              2: c = {2'b01, 1'b1, 1'b0, 2'b00}; // even
              3: c = {2'b11, 1'b1, 1'b0, 2'b00}; // stick 0
              default: c = {2'b10, 1'b1, 1'b0, 2'b00}; // stick 1
            endcase
            c[2] = st[0];
            c[1:0] = wl[1:0];
            line_ctl = c;
            offer({8'h00, pats[di]}, e);
            check_frame(e, pats[di], c);
          end

    // R10: upper bits ignored
    line_ctl = 6'b001011;
    offer(16'h5AC3, e);
    check_frame(e, 8'hC3, 6'b001011);

    // R3: slower tick, timing follows tick16
    tick_p = 3;
    line_ctl = 6'b011111;
    offer(16'h0096, e);
    check_frame(e, 8'h96, 6'b011111);
    tick_p = 1;

    // R8: flow control disabled ignores cts
    cts_flow_en = 1'b0; cts_in = 1'b0;
    line_ctl = 6'b000011;
    offer(16'h0011, e);
    check_frame(e, 8'h11, 6'b000011);

    // R8: flow control blocks start until cts synchronised
    cts_flow_en = 1'b1;
    @(negedge clk);
    in_data = 16'h00E7; in_valid = 1'b1;
    repeat (20) @(negedge clk);
    chk(in_ready == 1'b0, "R8 blocked by cts", int'(in_ready), 0);
    chk(busy == 1'b0 && tx_line == 1'b1, "R8 no frame while cts low", int'(tx_line), 1);
    cts_in = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R8 sync latency one edge", int'(in_ready), 0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready after two edges", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    e = cyc;
    // R9: disturb everything mid-frame; frame still uses captured settings
    cts_in = 1'b0; en_tx = 1'b0; line_ctl = 6'b100000;
    check_frame(e, 8'hE7, 6'b000011);
    chk(in_ready == 1'b0, "R9 stays idle after frame when disabled", int'(in_ready), 0);

    summary();
  end
endmodule